// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block shapes one external static memory access at a time. An internal requester presents a read or write request together with an address, write data and a set of timing fields. The block then drives an active-low chip select, active-low read and write strobes, the output enable of the data bus and the outgoing data. For reads it returns the sampled bus value, and it pulses `done` when the access is finished.

All timing is counted in half memory cycles. The block runs on a clock at twice the memory cycle rate, so one tick of `clk2x` is one half cycle. The setup and hold encodings differ between reads and writes. Chip select can be trimmed at both ends. An early read mode removes setup and hold from reads.

A configuration that would make the external device misbehave is refused. The block does not start an access for it and instead raises a one-tick error pulse.

Top module: `smem_strobe_gen`

## Requirements
- R1: After reset, `ready`=1, `mem_cs_n`=`mem_rd_n`=`mem_wr_n`=1, `mem_dq_oe`=0, `done`=0 and `cfg_err`=0.
- R2: Tick 0 is the first tick after the edge that accepts a request. In a write, `mem_wr_n` falls at tick 1 for a setup code of 0 and at tick 2N+1 for a setup code N of 1 to 7.
- R3: A standard read (`cfg_early`=0) uses the same setup encoding on `mem_rd_n` as R2.
- R4: The hold is counted from the tick the strobe rises to the end of the access. For a hold code N of 1 to 7 it is 2N ticks for both reads and writes. For a hold code of 0 it is 0 ticks for a read and 1 tick for a write.
- R5: The strobe stays low for 2*(1+W) ticks, where W is the 3-bit `cfg_wait`.
- R6: In an early read, `mem_rd_n` falls at tick 0 and the access ends when the strobe rises. `cfg_setup` and `cfg_hold` have no effect on the waveform. Writes keep the R2 and R4 timing.
- R7: Let T be the access length in ticks (setup+pulse+hold) and C be `cfg_csoff`. `mem_cs_n` is low from tick 2C up to, but not including, tick T-2C.
- R8: Width code 1 selects a 16-bit bus with all 16 bits transferred. Width code 2 selects an 8-bit bus: `mem_dq_out[15:8]` is 0 and `rd_data[15:8]` is returned as 0.
- R9: A request with a nonzero setup code, a zero hold code and a zero wait count starts no access. `cfg_err` is 1 for the one tick after it and `ready` stays 1.
- R10: A reserved width code (0 or 3) is a configuration error treated as in R9. So is a trim with 4C >= T.
- R11: `ready` is 1 only while idle. `done` is high for exactly one tick, tick T. A read returns the bus value that was present during the last low tick of `mem_rd_n`, and it is valid in `rd_data` from tick T on.
- R12: `mem_rd_n` and `mem_wr_n` are never low together. `mem_dq_oe` is 1 from tick 0 to T-1 of writes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the memory cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when `ready` is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | 16 | Write data |
| cfg_setup | input | 3 | Setup code |
| cfg_hold | input | 3 | Hold code |
| cfg_wait | input | 3 | Extra full cycles added to the strobe pulse |
| cfg_csoff | input | 2 | Chip-select trim, in full cycles at each end |
| cfg_early | input | 1 | 1 = early read mode |
| cfg_width | input | 2 | Bus width code: 1 = 16-bit, 2 = 8-bit |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-tick pulse at the end of an access |
| cfg_err | output | 1 | One-tick pulse after a refused request |
| rd_data | output | 16 | Last read data |
| mem_addr | output | AW | Address held for the access |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_out | output | 16 | Data driven onto the bus |
| mem_dq_in | input | 16 | Data sampled from the bus |

## Verification
The hardest case to reach is the read sample point. A bus that holds one value for the whole access cannot show whether data was taken at the last low tick of the strobe or one tick later. To tell the two apart, the stimulus changes `mem_dq_in` to a junk value on the same half cycle in which `mem_rd_n` is seen rising, and then expects the earlier value. The illegal setup/hold case and the trim boundary (4C equal to T against 4C just below T) are each reached with one chosen field set, and the bench confirms that no strobe moves after a refused request.

// File: rtl/smem_strobe_gen.sv
module smem_strobe_gen #(
  parameter int AW = 16,
  parameter int CW = 6
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [2:0]    cfg_setup,
  input  logic [2:0]    cfg_hold,
  input  logic [2:0]    cfg_wait,
  input  logic [1:0]    cfg_csoff,
  input  logic          cfg_early,
  input  logic [1:0]    cfg_width,
  output logic          ready,
  output logic          done,
  output logic          cfg_err,
  output logic [15:0]   rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic          mem_dq_oe,
  output logic [15:0]   mem_dq_out,
  input  logic [15:0]   mem_dq_in
);

  typedef enum logic [1:0] {IDLE, RUN, FIN} state_t;
  state_t state;

  logic [CW-1:0] cnt, soff_q, pend_q, tot_q, coff_q, cend_q;
  logic [CW-1:0] s_hc, h_hc, p_hc, tot_hc, c_hc;
  logic          we_q, byte_q, early_rd;
  logic          bad_sh, bad_w, bad_cs, bad;
  logic [15:0]   wdata_q;
  logic          run, strobe;

  assign early_rd = !req_we && cfg_early;

  always_comb begin
    if (early_rd)             s_hc = '0;
    else if (cfg_setup == 0)  s_hc = CW'(1);
    else                      s_hc = CW'({cfg_setup, 1'b1});

    if (early_rd)             h_hc = '0;
    else if (cfg_hold == 0)   h_hc = req_we ? CW'(1) : '0;
    else                      h_hc = CW'({cfg_hold, 1'b0});

    p_hc   = CW'({({1'b0, cfg_wait} + 4'd1), 1'b0});
    tot_hc = s_hc + p_hc + h_hc;
    c_hc   = CW'({cfg_csoff, 1'b0});
  end

  assign bad_sh = (cfg_setup != 0) && (cfg_hold == 0) && (cfg_wait == 0);
  assign bad_w  = (cfg_width == 2'd0) || (cfg_width == 2'd3);
  assign bad_cs = CW'({cfg_csoff, 2'b00}) >= tot_hc;
  assign bad    = bad_sh || bad_w || bad_cs;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      cnt      <= '0;
      soff_q   <= '0;
      pend_q   <= '0;
      tot_q    <= '0;
      coff_q   <= '0;
      cend_q   <= '0;
      we_q     <= 1'b0;
      byte_q   <= 1'b0;
      wdata_q  <= '0;
      mem_addr <= '0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= 1'b0;
      case (state)
        IDLE: if (req) begin
          if (bad) begin
            cfg_err <= 1'b1;
          end else begin
            state    <= RUN;
            cnt      <= '0;
            soff_q   <= s_hc;
            pend_q   <= s_hc + p_hc;
            tot_q    <= tot_hc;
            coff_q   <= c_hc;
            cend_q   <= tot_hc - c_hc;
            we_q     <= req_we;
            byte_q   <= (cfg_width == 2'd2);
            wdata_q  <= req_wdata;
            mem_addr <= req_addr;
          end
        end
        RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == tot_q - 1'b1) state <= FIN;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (run && !we_q && cnt == pend_q - 1'b1)
      rd_data <= byte_q ? {8'h00, mem_dq_in[7:0]} : mem_dq_in;
  end

  assign run        = (state == RUN);
  assign ready      = (state == IDLE);
  assign done       = (state == FIN);
  assign strobe     = run && (cnt >= soff_q) && (cnt < pend_q);
  assign mem_cs_n   = !(run && (cnt >= coff_q) && (cnt < cend_q));
  assign mem_rd_n   = !(strobe && !we_q);
  assign mem_wr_n   = !(strobe && we_q);
  assign mem_dq_oe  = run && we_q;
  assign mem_dq_out = byte_q ? {8'h00, wdata_q[7:0]} : wdata_q;

endmodule

// File: rtl/smem_strobe_chk.sv
module smem_strobe_chk (
  input logic clk2x,
  input logic rst_n,
  input logic ready,
  input logic done,
  input logic cfg_err,
  input logic mem_cs_n,
  input logic mem_rd_n,
  input logic mem_wr_n,
  input logic mem_dq_oe
);

  a_r12_strobe_excl: assert property (@(posedge clk2x) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  a_r12_oe_not_read: assert property (@(posedge clk2x) disable iff (!rst_n)
    mem_dq_oe |-> mem_rd_n);

  a_r11_idle_quiet: assert property (@(posedge clk2x) disable iff (!rst_n)
    ready |-> (mem_cs_n && mem_rd_n && mem_wr_n && !mem_dq_oe));

  a_r11_done_single: assert property (@(posedge clk2x) disable iff (!rst_n)
    done |=> (!done && ready));

  a_r9_err_no_start: assert property (@(posedge clk2x) disable iff (!rst_n)
    cfg_err |-> (ready && mem_cs_n && !done));

endmodule

bind smem_strobe_gen smem_strobe_chk u_chk (
  .clk2x(clk2x), .rst_n(rst_n), .ready(ready), .done(done), .cfg_err(cfg_err),
  .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/smem_strobe_gen_tb.sv
module smem_strobe_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic clk2x = 0, rst_n = 0;
  logic req = 0, req_we = 0, cfg_early = 0;
  logic [15:0] req_addr = 0, req_wdata = 0, mem_dq_in = 0;
  logic [2:0] cfg_setup = 0, cfg_hold = 0, cfg_wait = 0;
  logic [1:0] cfg_csoff = 0, cfg_width = 1;
  logic ready, done, cfg_err, mem_cs_n, mem_rd_n, mem_wr_n, mem_dq_oe;
  logic [15:0] rd_data, mem_addr, mem_dq_out;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  smem_strobe_gen u_dut (.*);

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish (act=hang exp=finish)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d (0x%0h) exp=%0d (0x%0h)", r, act, act, exp, exp);
    end
  endtask

  function automatic int e_set(bit we, bit early, int s);
    if (!we && early) return 0;
    return (s == 0) ? 1 : 2*s + 1;
  endfunction
  function automatic int e_hold(bit we, bit early, int h);
    if (!we && early) return 0;
    if (h == 0) return we ? 1 : 0;
    return 2*h;
  endfunction

  int st_first, st_len, other_len, cs_first, cs_len, oe_len, done_idx, dq_seen;

  task automatic access(bit we, int s, int h, int w, int c, bit early, int wd,
                        logic [15:0] wdat, logic [15:0] din);
    bit seen_low;
    @(negedge clk2x);
    req = 1; req_we = we; req_addr = 16'h1234; req_wdata = wdat;
    cfg_setup = 3'(s); cfg_hold = 3'(h); cfg_wait = 3'(w);
    cfg_csoff = 2'(c); cfg_early = early; cfg_width = 2'(wd); mem_dq_in = din;
    st_first = -1; st_len = 0; other_len = 0; cs_first = -1; cs_len = 0;
    oe_len = 0; done_idx = -1; dq_seen = 0; seen_low = 0;
    @(posedge clk2x);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk2x);
      req = 0;
      if (!(we ? mem_wr_n : mem_rd_n)) begin
        if (st_first < 0) st_first = i;
        st_len++; seen_low = 1;
      end else if (seen_low && !we) begin
        mem_dq_in = 16'hDEAD; seen_low = 0;
      end
      if (!(we ? mem_rd_n : mem_wr_n)) other_len++;
      if (!mem_cs_n) begin if (cs_first < 0) cs_first = i; cs_len++; end
      if (mem_dq_oe) begin oe_len++; dq_seen = mem_dq_out; end
      if (done) begin done_idx = i; break; end
    end
  endtask

  task automatic check_access(string r, bit we, int s, int h, int w, int c, bit early);
    int S = e_set(we, early, s);
    int P = 2*(1+w);
    int T = S + P + e_hold(we, early, h);
    chk({r, " strobe start"}, st_first, S);
    chk("R5 strobe length", st_len, P);
    chk({r, " hold/end"}, done_idx - (st_first + st_len), T - S - P);
    chk("R12 other strobe idle", other_len, 0);
    chk("R7 cs start", cs_first, 2*c);
    chk("R7 cs length", cs_len, T - 4*c);
    chk("R11 done tick", done_idx, T);
    chk("R12 oe length", oe_len, we ? T : 0);
  endtask

  task automatic t_reset;
    chk("R1 ready", ready, 1);
    chk("R1 strobes", {mem_cs_n, mem_rd_n, mem_wr_n}, 3'b111);
    chk("R1 oe/done/err", {mem_dq_oe, done, cfg_err}, 3'b000);
  endtask

  task automatic t_write_setup;
    for (int s = 0; s < 8; s += 3) begin
      access(1, s, 2, 0, 0, 0, 1, 16'hA55A, 0);
      check_access("R2", 1, s, 2, 0, 0, 0);
    end
    chk("R8 16-bit write data", dq_seen, 16'hA55A);
  endtask

  task automatic t_read_std;
    for (int s = 0; s < 8; s += 7) begin
      access(0, s, 1, 1, 0, 0, 1, 0, 16'hBEEF);
      check_access("R3", 0, s, 1, 1, 0, 0);
      chk("R11 read data sampled at last strobe tick", rd_data, 16'hBEEF);
    end
  endtask

  task automatic t_hold;
    access(0, 0, 0, 0, 0, 0, 1, 0, 16'h0101);
    check_access("R4 read h0", 0, 0, 0, 0, 0, 0);
    access(1, 0, 0, 0, 0, 0, 1, 16'h0202, 0);
    check_access("R4 write h0", 1, 0, 0, 0, 0, 0);
    access(1, 2, 5, 0, 0, 0, 1, 16'h0303, 0);
    check_access("R4 write h5", 1, 2, 5, 0, 0, 0);
  endtask

  task automatic t_wait;
    access(1, 1, 1, 7, 0, 0, 1, 16'h7777, 0);
    check_access("R5", 1, 1, 1, 7, 0, 0);
  endtask

  task automatic t_early;
    access(0, 5, 3, 0, 0, 1, 1, 0, 16'hC0DE);
    check_access("R6", 0, 5, 3, 0, 0, 1);
    chk("R6 setup/hold ignored: access length", done_idx, 2);
    chk("R6 early read data", rd_data, 16'hC0DE);
    access(1, 1, 1, 0, 0, 1, 1, 16'h1111, 0);
    check_access("R6 write keeps timing", 1, 1, 1, 0, 0, 1);
  endtask

  task automatic t_cs;
    access(0, 3, 3, 0, 2, 0, 1, 0, 16'h4444);
    check_access("R7", 0, 3, 3, 0, 2, 0);
    access(1, 1, 1, 0, 1, 0, 1, 16'h5555, 0);
    check_access("R7 trim 1", 1, 1, 1, 0, 1, 0);
  endtask

  task automatic t_width;
    access(1, 1, 1, 0, 0, 0, 2, 16'hABCD, 0);
    chk("R8 8-bit write upper zero", dq_seen, 16'h00CD);
    access(0, 1, 1, 0, 0, 0, 2, 0, 16'h9876);
    chk("R8 8-bit read upper zero", rd_data, 16'h0076);
  endtask

  task automatic refused(string r, bit we, int s, int h, int w, int c, bit early, int wd);
    int moved = 0;
    @(negedge clk2x);
    req = 1; req_we = we; cfg_setup = 3'(s); cfg_hold = 3'(h); cfg_wait = 3'(w);
    cfg_csoff = 2'(c); cfg_early = early; cfg_width = 2'(wd);
    @(negedge clk2x);
    req = 0;
    chk({r, " error pulse"}, cfg_err, 1);
    chk({r, " ready kept"}, ready, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk2x);
      if (!mem_cs_n || !mem_rd_n || !mem_wr_n || done || cfg_err) moved++;
    end
    chk({r, " no access started"}, moved, 0);
  endtask

  task automatic t_illegal;
    refused("R9", 1, 2, 0, 0, 0, 0, 1);
    access(1, 2, 0, 1, 0, 0, 1, 16'h2222, 0);
    check_access("R9 legal with wait", 1, 2, 0, 1, 0, 0);
  endtask

  task automatic t_reserved;
    refused("R10 width 0", 0, 1, 1, 0, 0, 0, 0);
    refused("R10 width 3", 1, 1, 1, 0, 0, 0, 3);
    refused("R10 trim 4C==T", 0, 0, 0, 1, 1, 1, 1);
    access(0, 0, 0, 2, 1, 1, 1, 0, 16'h3333);
    check_access("R10 trim 4C<T", 0, 0, 0, 2, 1, 1);
  endtask

  initial begin
    #(CLK_PERIOD*3);
    @(negedge clk2x);
    t_reset();
    rst_n = 1;
    t_write_setup();
    t_read_std();
    t_hold();
    t_wait();
    t_early();
    t_cs();
    t_width();
    t_illegal();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule